// File: doc/BRIEF.md
# Asynchronous SRAM access sequencer

This block lets a synchronous on-chip requester read and write an external asynchronous static RAM of 16,384 four-bit words. The requester side is a valid/ready handshake that carries an address, write data and a direction bit. Read data comes back with a one-cycle valid strobe. On the memory side the block drives active-low chip select, write strobe and output enable, a 14-bit address, and a split data bus made of an outgoing value, a drive enable and an incoming value. The pad ring joins these three into the bidirectional pins.

The memory's timing minimums are given as nanosecond parameters together with the clock period. The block rounds each interval up to a whole number of clock cycles and runs every access from those counts. A write is the window in which chip select and write strobe are both low. The window closes when both rise on the same edge, and the data stays on the bus for a recovery period after that. A read holds chip select and output enable low for the access time and samples the data on the last of those cycles. It then leaves the bus idle for a turnaround period before the next request can start. Between accesses chip select stays high, so the memory sits in its low-power deselected state.

Top module: `asram_ctrl`

## Requirements
- R1: While rst_n is low, mem_ce_n, mem_we_n and mem_oe_n are 1, mem_dq_drive is 0, and req_ready and rsp_valid are 0. Asserting rst_n forces the strobes high at once, without waiting for a clock edge.
- R2: When no request is pending, mem_ce_n, mem_we_n and mem_oe_n stay 1 and mem_dq_drive stays 0.
- R3: A write holds mem_ce_n and mem_we_n low together for exactly WP = ceil(max(T_PWE_NS, T_SD_NS, T_AW_NS) / CLK_NS) cycles. mem_we_n is low only while mem_ce_n is low.
- R4: For a write, mem_dq_drive is 1 for WP + WR cycles, starting in the first strobe cycle, where WR = max(1, ceil(T_WC_NS / CLK_NS) - WP). mem_dq_out carries the accepted write data unchanged for that whole time. Drive therefore continues for at least one cycle after mem_we_n rises.
- R5: mem_oe_n is 1 whenever mem_we_n is 0 or mem_dq_drive is 1, and it stays 1 for the whole of a write.
- R6: A read holds mem_ce_n and mem_oe_n low, with mem_we_n high, for exactly RD = ceil(T_AA_NS / CLK_NS) cycles. mem_dq_in is sampled on the clock edge that ends the last of those cycles.
- R7: rsp_valid is a single-cycle pulse in cycle RD + 1 after the accepting edge, and rsp_rdata holds the sampled word during that cycle. A write produces no pulse.
- R8: mem_addr is loaded from req_addr on the accepting edge. It does not change while any strobe is low.
- R9: After a read, the strobes are high and the bus is undriven for TR = ceil(T_HZ_NS / CLK_NS) cycles before req_ready returns. A read keeps req_ready low for RD + TR cycles and a write for WP + WR cycles.
- R10: A request is accepted on a clock edge where req_valid and req_ready are both 1. Any request presented while req_ready is 0 is ignored and does not change memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and will accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read-data strobe |
| rsp_rdata | output | DATA_W | Read data |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data driven toward the memory |
| mem_dq_drive | output | 1 | Enables the pad drivers for mem_dq_out |
| mem_dq_in | input | DATA_W | Data received from the memory pins |

## Verification
The bench uses a 8 ns clock with T_AA_NS=25, T_PWE_NS=20, T_AW_NS=20, T_WC_NS=40 and T_HZ_NS=10. These values give RD=4, WP=3, WR=2 and TR=2, so every phase lasts more than one cycle. The write recovery phase is stretched to meet the full cycle time rather than taking its one-cycle floor. The memory model returns a corrupted word until the elapsed strobe time covers the access time, so a read that samples one cycle early is caught. The model also measures every write window and the data setup in cycles times the period, checks the hold after the strobes rise, and reports any cycle in which both sides drive the bus.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RACC,   // read strobes low, waiting out access time
    ST_RREC,   // read turnaround, bus released
    ST_WPUL,   // write window: select and write strobe low
    ST_WREC    // write recovery, data still driven
  } phase_e;

  function automatic int cdiv(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (cnt_q != '0)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_d;
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int CNT_W  = 2,
  parameter int RD_CYC = 2,
  parameter int WP_CYC = 2,
  parameter int WR_CYC = 1,
  parameter int TR_CYC = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_write,
  output logic req_ready,
  output logic accept,
  output logic capture,
  output logic ce_n,
  output logic we_n,
  output logic oe_n,
  output logic drive
);

  localparam logic [CNT_W-1:0] RD_L = CNT_W'(RD_CYC - 1);
  localparam logic [CNT_W-1:0] WP_L = CNT_W'(WP_CYC - 1);
  localparam logic [CNT_W-1:0] WR_L = CNT_W'(WR_CYC - 1);
  localparam logic [CNT_W-1:0] TR_L = CNT_W'(TR_CYC - 1);

  phase_e           state_q, state_d;
  logic             run_q;
  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             last;

  asram_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .last     (last)
  );

  assign req_ready = (state_q == ST_IDLE) && run_q;
  assign accept    = req_ready && req_valid;

  always_comb begin
    state_d  = state_q;
    load     = 1'b0;
    load_val = '0;
    capture  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d  = req_write ? ST_WPUL : ST_RACC;
        load     = 1'b1;
        load_val = req_write ? WP_L : RD_L;
      end
      ST_RACC: if (last) begin
        state_d  = ST_RREC;
        load     = 1'b1;
        load_val = TR_L;
        capture  = 1'b1;
      end
      ST_RREC: if (last) state_d = ST_IDLE;
      ST_WPUL: if (last) begin
        state_d  = ST_WREC;
        load     = 1'b1;
        load_val = WR_L;
      end
      ST_WREC: if (last) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // Strobes are registered from the next phase so the pins never glitch.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      run_q   <= 1'b0;
      ce_n    <= 1'b1;
      we_n    <= 1'b1;
      oe_n    <= 1'b1;
      drive   <= 1'b0;
    end else begin
      state_q <= state_d;
      run_q   <= 1'b1;
      ce_n    <= !((state_d == ST_RACC) || (state_d == ST_WPUL));
      we_n    <= !(state_d == ST_WPUL);
      oe_n    <= !(state_d == ST_RACC);
      drive   <= (state_d == ST_WPUL) || (state_d == ST_WREC);
    end
  end

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] dq_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      dq_out   <= '0;
    end else if (accept) begin
      mem_addr <= req_addr;
      dq_out   <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rsp_rdata <= '0;
    else if (capture)
      rsp_rdata <= dq_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rsp_valid <= 1'b0;
    else
      rsp_valid <= capture;
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int DATA_W   = 4,
  parameter int CLK_NS   = 8,
  parameter int T_AA_NS  = 15,
  parameter int T_PWE_NS = 12,
  parameter int T_SD_NS  = 10,
  parameter int T_AW_NS  = 12,
  parameter int T_WC_NS  = 15,
  parameter int T_HZ_NS  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_drive,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int RD_CYC = imax(1, cdiv(T_AA_NS, CLK_NS));
  localparam int WP_CYC = imax(1, cdiv(imax(T_PWE_NS, imax(T_SD_NS, T_AW_NS)), CLK_NS));
  localparam int WC_CYC = cdiv(T_WC_NS, CLK_NS);
  localparam int WR_CYC = imax(1, WC_CYC - WP_CYC);
  localparam int TR_CYC = imax(1, cdiv(T_HZ_NS, CLK_NS));
  localparam int MAX_CYC = imax(imax(RD_CYC, WP_CYC), imax(WR_CYC, TR_CYC));
  localparam int CNT_W  = imax(1, $clog2(MAX_CYC + 1));

  logic rst_meta_q, rst_sync_q;
  logic accept, capture;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  asram_seq #(
    .CNT_W  (CNT_W),
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC),
    .WR_CYC (WR_CYC),
    .TR_CYC (TR_CYC)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_ready (req_ready),
    .accept    (accept),
    .capture   (capture),
    .ce_n      (mem_ce_n),
    .we_n      (mem_we_n),
    .oe_n      (mem_oe_n),
    .drive     (mem_dq_drive)
  );

  asram_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) u_dpath (
    .clk       (clk),
    .rst_n     (rst_sync_q),
    .accept    (accept),
    .capture   (capture),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .dq_in     (mem_dq_in),
    .mem_addr  (mem_addr),
    .dq_out    (mem_dq_out),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_drive
);

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_drive));

  p_we_inside_ce_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);

  p_hold_after_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_drive);

  p_drive_during_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_dq_drive);

  p_no_contention_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_dq_drive || !mem_we_n) |-> mem_oe_n);

  p_rsp_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

  p_rsp_after_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (mem_ce_n && mem_oe_n));

endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .mem_ce_n     (mem_ce_n),
  .mem_we_n     (mem_we_n),
  .mem_oe_n     (mem_oe_n),
  .mem_addr     (mem_addr),
  .mem_dq_drive (mem_dq_drive)
);

// File: tb/asram_ctrl_tb.sv
module asram_ctrl_tb;

  localparam int CLK_NS = 8;
  localparam int T_AA   = 25;
  localparam int T_PWE  = 20;
  localparam int T_SD   = 10;
  localparam int T_AW   = 20;
  localparam int T_WC   = 40;
  localparam int T_HZ   = 10;

  // Expected cycle counts, from the rounding rules in the requirements
  localparam int E_RD = (T_AA + CLK_NS - 1) / CLK_NS;                  // 4
  localparam int E_WP = (T_PWE + CLK_NS - 1) / CLK_NS;                 // 3
  localparam int E_WR = ((T_WC + CLK_NS - 1) / CLK_NS) - E_WP;         // 2
  localparam int E_TR = (T_HZ + CLK_NS - 1) / CLK_NS;                  // 2

  // vector: {write, addr[13:0], wdata[3:0], expected[3:0]}
  localparam int NV = 12;
  localparam logic [22:0] VEC [NV] = '{
    {1'b1, 14'h0000, 4'hA, 4'h0},
    {1'b1, 14'h3FFF, 4'h5, 4'h0},
    {1'b1, 14'h1234, 4'hC, 4'h0},
    {1'b0, 14'h0000, 4'h0, 4'hA},
    {1'b0, 14'h3FFF, 4'h0, 4'h5},
    {1'b1, 14'h0000, 4'h3, 4'h0},
    {1'b0, 14'h0000, 4'h0, 4'h3},
    {1'b0, 14'h1234, 4'h0, 4'hC},
    {1'b1, 14'h2AAA, 4'hF, 4'h0},
    {1'b1, 14'h1555, 4'h0, 4'h0},
    {1'b0, 14'h2AAA, 4'h0, 4'hF},
    {1'b0, 14'h1555, 4'h0, 4'h0}
  };

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_write;
  logic [13:0] req_addr;
  logic [3:0]  req_wdata;
  logic        rsp_valid;
  logic [3:0]  rsp_rdata;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_drive;
  logic [13:0] mem_addr;
  logic [3:0]  mem_dq_out, mem_dq_in;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  asram_ctrl #(
    .ADDR_W(14), .DATA_W(4), .CLK_NS(CLK_NS), .T_AA_NS(T_AA),
    .T_PWE_NS(T_PWE), .T_SD_NS(T_SD), .T_AW_NS(T_AW),
    .T_WC_NS(T_WC), .T_HZ_NS(T_HZ)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n),
    .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_drive(mem_dq_drive), .mem_dq_in(mem_dq_in)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- behavioural memory model ----------------
  logic [3:0]  mem [int];
  int          rd_age = 0;
  bit          pw = 0;
  int          wov = 0, dst = 0;
  logic [13:0] waddr = '0;
  logic [3:0]  dlast = '0;

  function automatic logic [3:0] peek(input logic [13:0] a);
    return mem.exists(int'(a)) ? mem[int'(a)] : 4'h0;
  endfunction

  always_comb begin
    if (!mem_ce_n && !mem_oe_n && mem_we_n && (rd_age * CLK_NS >= T_AA))
      mem_dq_in = peek(mem_addr);
    else
      mem_dq_in = ~peek(mem_addr);
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_dq_drive && !mem_ce_n && !mem_oe_n)
        chk(0, "R5 bus contention", 1, 0);
      if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_age = rd_age + 1;
      else rd_age = 0;
      if (!mem_ce_n && !mem_we_n) begin
        if (!pw) begin
          wov = 1; waddr = mem_addr;
        end else begin
          wov = wov + 1;
          if (mem_addr !== waddr) chk(0, "R8 address moved in write", int'(mem_addr), int'(waddr));
        end
        if (!mem_oe_n) chk(0, "R5 output enable low during write", 0, 1);
        if (mem_dq_drive) begin
          dst = (pw && mem_dq_out === dlast) ? dst + 1 : 1;
          dlast = mem_dq_out;
        end else dst = 0;
        pw = 1;
      end else if (pw) begin
        chk(wov * CLK_NS >= T_PWE, "R3 write window ns", wov * CLK_NS, T_PWE);
        chk(dst * CLK_NS >= T_SD, "R4 data setup ns", dst * CLK_NS, T_SD);
        chk(mem_dq_drive && mem_dq_out === dlast, "R4 data hold after strobe", int'(mem_dq_drive), 1);
        mem[int'(waddr)] = dlast;
        pw = 0;
      end
    end
  end

  // ---------------- one request through the handshake ----------------
  task automatic run_op(input bit wr, input logic [13:0] a, input logic [3:0] d,
                        input logic [3:0] ex, input bit intrude);
    int n = 0, ce_c = 0, we_c = 0, oe_c = 0, dr_c = 0, rsp_c = 0, rsp_at = 0;
    bit addr_bad = 0;
    logic [3:0] got = '0;
    while (req_ready !== 1'b1) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    do begin
      @(negedge clk);
      n++;
      if (n == 1) begin
        if (intrude) begin req_write = 1'b1; req_addr = 14'h0000; req_wdata = 4'h9; end
        else req_valid = 1'b0;
      end
      if (n == 2) req_valid = 1'b0;
      if (!mem_ce_n) begin ce_c++; if (mem_addr !== a) addr_bad = 1; end
      if (!mem_we_n) we_c++;
      if (!mem_oe_n) oe_c++;
      if (mem_dq_drive) begin
        dr_c++;
        if (mem_dq_out !== d) addr_bad = 1;
      end
      if (rsp_valid) begin rsp_c++; rsp_at = n; got = rsp_rdata; end
    end while (req_ready !== 1'b1 && n < 100);
    chk(!addr_bad, "R8 address/data held during access", int'(addr_bad), 0);
    if (wr) begin
      chk(we_c == E_WP && ce_c == E_WP, "R3 write strobe cycles", we_c, E_WP);
      chk(dr_c == E_WP + E_WR, "R4 drive cycles", dr_c, E_WP + E_WR);
      chk(oe_c == 0, "R5 output enable during write", oe_c, 0);
      chk(rsp_c == 0, "R7 no response for write", rsp_c, 0);
      chk(n - 1 == E_WP + E_WR, "R9 write busy cycles", n - 1, E_WP + E_WR);
    end else begin
      chk(ce_c == E_RD && oe_c == E_RD && we_c == 0, "R6 read strobe cycles", ce_c, E_RD);
      chk(dr_c == 0, "R5 no drive during read", dr_c, 0);
      chk(rsp_c == 1 && rsp_at == E_RD + 1, "R7 response pulse cycle", rsp_at, E_RD + 1);
      chk(got === ex, "R6 read data", int'(got), int'(ex));
      chk(n - 1 == E_RD + E_TR, "R9 read busy cycles", n - 1, E_RD + E_TR);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R10 watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_drive, "R1 strobes in reset",
        int'({mem_ce_n, mem_we_n, mem_oe_n, mem_dq_drive}), 4'b1110);
    chk(!req_ready && !rsp_valid, "R1 handshake in reset", int'({req_ready, rsp_valid}), 0);
    rst_n = 1'b1;

    // vector table
    for (int i = 0; i < NV; i++)
      run_op(VEC[i][22], VEC[i][21:8], VEC[i][7:4], VEC[i][3:0], 1'b0);

    // R10: request presented while busy is ignored
    run_op(1'b0, 14'h1234, 4'h0, 4'hC, 1'b1);
    run_op(1'b0, 14'h0000, 4'h0, 4'h3, 1'b0);

    // write immediately followed by read of the same word (turnaround)
    run_op(1'b1, 14'h0ABC, 4'h6, 4'h0, 1'b0);
    run_op(1'b0, 14'h0ABC, 4'h0, 4'h6, 1'b0);

    // R2: idle with no request
    begin
      int act = 0;
      for (int k = 0; k < 6; k++) begin
        @(negedge clk);
        if (!mem_ce_n || !mem_we_n || !mem_oe_n || mem_dq_drive) act++;
      end
      chk(act == 0, "R2 idle strobes", act, 0);
    end

    // R1: reset asserted in the middle of a read
    begin
      int stray = 0;
      while (req_ready !== 1'b1) @(negedge clk);
      req_valid = 1'b1; req_write = 1'b0; req_addr = 14'h3FFF;
      @(negedge clk); req_valid = 1'b0;
      @(negedge clk);
      chk(!mem_ce_n, "R6 read in progress before reset", int'(mem_ce_n), 0);
      rst_n = 1'b0;
      #1;
      chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 asynchronous strobe release",
          int'({mem_ce_n, mem_oe_n, mem_we_n}), 7);
      repeat (3) begin @(negedge clk); if (rsp_valid) stray++; end
      rst_n = 1'b1;
      repeat (3) begin @(negedge clk); if (rsp_valid) stray++; end
      chk(stray == 0, "R1 no response after reset", stray, 0);
    end
    run_op(1'b0, 14'h3FFF, 4'h0, 4'h5, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule